// File: doc/BRIEF.md
# Big-Endian Byte-Lane Steering Unit

This block sits between a processor's load/store stage and a data memory that is one 32-bit word wide. The memory is byte addressed and every word starts on a 4-byte boundary. On the request side, a byte address, a size code and store data go in. One clock later the block presents a word-aligned memory address and four byte-enables. For a write it also presents the store data placed on the byte lanes the access covers. On the return side, the word read from memory goes in together with the low address bits, the size code and a signedness flag. One clock later the block presents the addressed byte, halfword or word, extended to the full 32 bits.

Lane order is big-endian: the most significant byte of a word sits at the lowest address. For the word 0xabcdef12, byte 0xab is at offset 0, 0xcd at offset 1, 0xef at offset 2 and 0x12 at offset 3. A sub-word access whose address does not fit its size raises a misalignment flag. No byte-enable is asserted and no data is produced for such an access. Raising that flag is the only error handling in the block.

Top module: `belsu_top`

## Requirements
- R1: The size code is 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 illegal. One cycle after an accepted request, `mem_valid` is 1 and `mem_addr` equals `req_addr` with bits 1:0 forced to 0.
- R2: An aligned word request gives `mem_be` = 4'b1111. For a write, `mem_wdata` equals `req_wdata` unchanged.
- R3: A halfword request at offset 0 gives `mem_be` = 4'b1100, and at offset 2 gives 4'b0011. For a write, `mem_wdata` carries `req_wdata[15:0]` in both bits 31:16 and bits 15:0.
- R4: A byte request at offset k sets only `mem_be` bit 3-k (bit 3 is offset 0, bits 31:24). For a write, `mem_wdata` carries `req_wdata[7:0]` on all four lanes.
- R5: A halfword request with address bit 0 set, a word request with address bits 1:0 not 00, or any request with size 2'b11 gives `req_misalign` = 1, `mem_valid` = 0 and `mem_be` = 0 one cycle later. A byte request is never misaligned.
- R6: A word load returns `mem_rdata` unchanged on `load_data`, one cycle after `rsp_valid`.
- R7: A signed byte or halfword load (`rsp_unsigned` = 0) takes the byte at offset k from bits 31-8k:24-8k, or the halfword at offset 0 or 2 from bits 31:16 or 15:0. It copies the sign bit of that value into all upper result bits.
- R8: An unsigned byte or halfword load (`rsp_unsigned` = 1) extracts the same bits as R7 and fills all upper result bits with 0.
- R9: A load whose offset does not fit its size, following the rule in R5, gives `load_valid` = 1, `load_misalign` = 1 and `load_data` = 0.
- R10: While `rst` is high, and in the first cycle after it falls, every output is 0.
- R11: A cycle with `req_valid` = 0 gives `mem_valid` = 0, `mem_be` = 0 and `mem_wdata` = 0 in the next cycle. A cycle with `rsp_valid` = 0 gives `load_valid` = 0 and `load_data` = 0 in the next cycle.
- R12: A read request (`req_write` = 0) gets the same address and byte-enables as a write of that size, and `mem_wdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load request |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Store source value, right-aligned |
| rsp_valid | input | 1 | Memory read word present |
| rsp_offset | input | 2 | Low address bits of the load |
| rsp_size | input | 2 | Size code of the load |
| rsp_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| mem_rdata | input | 32 | Word read from memory |
| mem_valid | output | 1 | Aligned access issued to memory |
| mem_write | output | 1 | Issued access is a store |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Store data on its lanes |
| req_misalign | output | 1 | Request was misaligned |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |
| load_misalign | output | 1 | Load offset was misaligned |

## Verification
Both paths have exactly one register stage. Each request or returned word therefore shows its result on the outputs in the clock cycle right after the edge that samples it. The bench changes inputs on the falling edge. It reads outputs on the next falling edge, which is half a period after the capturing rising edge. Each scenario then drops the valid input, so the following check also covers the idle behaviour of the cycle after it.

// File: rtl/belsu_pkg.sv
package belsu_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int LANE_W     = 8;
    localparam int DATA_W     = WORD_BYTES * LANE_W;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int HALF_W     = 2 * LANE_W;
    localparam int HALVES     = WORD_BYTES / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        acc_size_e         size;
        logic [DATA_W-1:0] wdata;
    } st_req_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [WORD_BYTES-1:0] be;
        logic [DATA_W-1:0] wdata;
        logic              misalign;
    } st_out_t;

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        acc_size_e         size;
        logic              is_unsigned;
        logic [DATA_W-1:0] rdata;
    } ld_rsp_t;

    // Returns 1 when the offset does not suit the access size.
    function automatic logic offset_bad(acc_size_e sz, logic [OFF_W-1:0] off);
        logic bad;
        case (sz)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = (off != '0);
            default: bad = 1'b1;
        endcase
        return bad;
    endfunction

    // Fills the upper bits with copies of the top bit of the given width.
    function automatic logic [DATA_W-1:0] widen(logic [DATA_W-1:0] v,
                                               int unsigned width,
                                               logic zero_fill);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < DATA_W; b++) begin
            if (b < int'(width))
                r[b] = v[b];
            else
                r[b] = zero_fill ? 1'b0 : v[width-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/belsu_store_steer.sv
module belsu_store_steer
    import belsu_pkg::*;
(
    input  acc_size_e             size,
    input  logic [OFF_W-1:0]      off,
    input  logic                  bad,
    input  logic [DATA_W-1:0]     wdata,
    output logic [WORD_BYTES-1:0] be,
    output logic [DATA_W-1:0]     lane_data
);

    // Lane i holds the byte at offset WORD_BYTES-1-i (big-endian order).
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(WORD_BYTES - 1 - i);

        logic hit;
        logic [LANE_W-1:0] src;

        always_comb begin
            case (size)
                SZ_BYTE: hit = (off == LANE_OFF);
                SZ_HALF: hit = (off[OFF_W-1:1] == LANE_OFF[OFF_W-1:1]);
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end

        always_comb begin
            case (size)
                SZ_BYTE: src = wdata[LANE_W-1:0];
                SZ_HALF: src = LANE_OFF[0] ? wdata[LANE_W-1:0]
                                           : wdata[HALF_W-1:LANE_W];
                default: src = wdata[i*LANE_W +: LANE_W];
            endcase
        end

        assign be[i]                        = hit & ~bad;
        assign lane_data[i*LANE_W +: LANE_W] = src;
    end

endmodule

// File: rtl/belsu_load_extract.sv
module belsu_load_extract
    import belsu_pkg::*;
(
    input  ld_rsp_t           rsp,
    input  logic              bad,
    output logic [DATA_W-1:0] result
);

    logic [LANE_W-1:0] byte_pick;
    logic [HALF_W-1:0] half_pick;

    // Offset 0 is the most significant lane.
    always_comb begin
        byte_pick = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (rsp.off == OFF_W'(WORD_BYTES - 1 - i))
                byte_pick = rsp.rdata[i*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        half_pick = '0;
        for (int j = 0; j < HALVES; j++) begin
            if (rsp.off[OFF_W-1:1] == (OFF_W-1)'(HALVES - 1 - j))
                half_pick = rsp.rdata[j*HALF_W +: HALF_W];
        end
    end

    always_comb begin
        if (bad) begin
            result = '0;
        end else begin
            case (rsp.size)
                SZ_BYTE: result = widen(DATA_W'(byte_pick), LANE_W, rsp.is_unsigned);
                SZ_HALF: result = widen(DATA_W'(half_pick), HALF_W, rsp.is_unsigned);
                default: result = rsp.rdata;
            endcase
        end
    end

endmodule

// File: rtl/belsu_top.sv
module belsu_top
    import belsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    input  logic        rsp_valid,
    input  logic [1:0]  rsp_offset,
    input  logic [1:0]  rsp_size,
    input  logic        rsp_unsigned,
    input  logic [31:0] mem_rdata,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    output logic        req_misalign,
    output logic        load_valid,
    output logic [31:0] load_data,
    output logic        load_misalign
);

    st_req_t   sreq;
    ld_rsp_t   lrsp;
    st_out_t   st_d, st_q;
    logic      st_bad, ld_bad;
    logic [WORD_BYTES-1:0] st_be;
    logic [DATA_W-1:0]     st_lanes, ld_result;
    logic [DATA_W-1:0]     ld_data_q;
    logic                  ld_valid_q, ld_mis_q;
    acc_size_e             st_size_q, ld_size_q;
    logic                  ld_uns_q;

    assign sreq = '{write: req_write, addr: req_addr,
                    size: acc_size_e'(req_size), wdata: req_wdata};
    assign lrsp = '{off: rsp_offset, size: acc_size_e'(rsp_size),
                    is_unsigned: rsp_unsigned, rdata: mem_rdata};

    assign st_bad = offset_bad(sreq.size, sreq.addr[OFF_W-1:0]);
    assign ld_bad = offset_bad(lrsp.size, lrsp.off);

    belsu_store_steer u_steer (
        .size      (sreq.size),
        .off       (sreq.addr[OFF_W-1:0]),
        .bad       (st_bad),
        .wdata     (sreq.wdata),
        .be        (st_be),
        .lane_data (st_lanes)
    );

    belsu_load_extract u_extract (
        .rsp    (lrsp),
        .bad    (ld_bad),
        .result (ld_result)
    );

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.valid    = ~st_bad;
            st_d.write    = sreq.write & ~st_bad;
            st_d.addr     = {sreq.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            st_d.be       = st_be;
            st_d.wdata    = (sreq.write && !st_bad) ? st_lanes : '0;
            st_d.misalign = st_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_size_q <= SZ_BYTE;
        end else begin
            st_q      <= st_d;
            st_size_q <= sreq.size;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid_q <= 1'b0;
            ld_mis_q   <= 1'b0;
            ld_data_q  <= '0;
            ld_size_q  <= SZ_BYTE;
            ld_uns_q   <= 1'b0;
        end else begin
            ld_valid_q <= rsp_valid;
            ld_mis_q   <= rsp_valid & ld_bad;
            ld_data_q  <= rsp_valid ? ld_result : '0;
            ld_size_q  <= lrsp.size;
            ld_uns_q   <= lrsp.is_unsigned;
        end
    end

    assign mem_valid     = st_q.valid;
    assign mem_write     = st_q.write;
    assign mem_addr      = st_q.addr;
    assign mem_be        = st_q.be;
    assign mem_wdata     = st_q.wdata;
    assign req_misalign  = st_q.misalign;
    assign load_valid    = ld_valid_q;
    assign load_data     = ld_data_q;
    assign load_misalign = ld_mis_q;

    // R1: issued address is always word aligned
    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_addr[OFF_W-1:0] == '0);

    // R2: a word access enables every lane
    assert_word_all_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && st_size_q == SZ_WORD) |-> mem_be == '1);

    // R3: a halfword access enables exactly two lanes
    assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && st_size_q == SZ_HALF) |-> $countones(mem_be) == 2);

    // R4: a byte access enables exactly one lane, holding the store byte
    assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && st_size_q == SZ_BYTE)
            |-> ($onehot0(mem_be) && mem_be != '0
                 && mem_wdata[LANE_W-1:0] == $past(req_wdata[LANE_W-1:0])));

    // R5: misaligned request stays off the memory
    assert_misalign_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        req_misalign |-> (mem_be == '0 && !mem_valid));

    // R7: signed byte load carries its sign upward
    assert_byte_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
        (load_valid && !load_misalign && !ld_uns_q && ld_size_q == SZ_BYTE)
            |-> load_data[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){load_data[LANE_W-1]}});

    // R8: unsigned sub-word load has clear upper bits
    assert_half_zero_ext_R8: assert property (@(posedge clk) disable iff (rst)
        (load_valid && !load_misalign && ld_uns_q && ld_size_q != SZ_WORD)
            |-> load_data[DATA_W-1:HALF_W] == '0);

    // R9: misaligned load yields no data
    assert_load_mis_zero_R9: assert property (@(posedge clk) disable iff (rst)
        load_misalign |-> (load_valid && load_data == '0));

    // R11: no request means no memory activity next cycle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_valid && mem_be == '0));

endmodule

// File: tb/belsu_top_tb.sv
module belsu_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, rsp_valid, rsp_unsigned;
    logic [31:0] req_addr, req_wdata, mem_rdata;
    logic [1:0]  req_size, rsp_offset, rsp_size;
    logic        mem_valid, mem_write, req_misalign, load_valid, load_misalign;
    logic [31:0] mem_addr, mem_wdata, load_data;
    logic [3:0]  mem_be;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    belsu_top u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_offset(rsp_offset), .rsp_size(rsp_size),
        .rsp_unsigned(rsp_unsigned), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .req_misalign(req_misalign),
        .load_valid(load_valid), .load_data(load_data),
        .load_misalign(load_misalign)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Expected values built from the requirement text.
    function automatic logic [3:0] want_be(logic [1:0] sz, logic [1:0] off);
        case (sz)
            2'b00: return 4'b1000 >> off;
            2'b01: return (off == 2'd0) ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] want_wdata(logic [1:0] sz, logic [31:0] d);
        case (sz)
            2'b00: return {4{d[7:0]}};
            2'b01: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] want_load(logic [1:0] sz, logic [1:0] off,
                                             logic uns, logic [31:0] w);
        logic [31:0] v;
        if (sz == 2'b00) begin
            v = (w >> (8 * (3 - off))) & 32'h0000_00ff;
            if (!uns && v[7]) v = v | 32'hffff_ff00;
        end else if (sz == 2'b01) begin
            v = (off == 2'd0) ? (w >> 16) : (w & 32'h0000_ffff);
            if (!uns && v[15]) v = v | 32'hffff_0000;
        end else begin
            v = w;
        end
        return v;
    endfunction

    task automatic idle_inputs();
        req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
        rsp_valid = 0; rsp_offset = 0; rsp_size = 0; rsp_unsigned = 0; mem_rdata = 0;
    endtask

    task automatic do_req(string tag, logic wr, logic [31:0] a, logic [1:0] sz,
                          logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        check({tag, " mem_valid"}, 32'(mem_valid), 32'd1);
        check({tag, " mem_addr"}, mem_addr, {a[31:2], 2'b00});
        check({tag, " mem_be"}, 32'(mem_be), 32'(want_be(sz, a[1:0])));
        check({tag, " mem_wdata"}, mem_wdata, wr ? want_wdata(sz, d) : 32'd0);
        check({tag, " req_misalign"}, 32'(req_misalign), 32'd0);
        req_valid = 0;
    endtask

    task automatic do_bad_req(logic [31:0] a, logic [1:0] sz);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = 32'hdead_beef;
        @(negedge clk);
        check("R5 req_misalign", 32'(req_misalign), 32'd1);
        check("R5 mem_valid", 32'(mem_valid), 32'd0);
        check("R5 mem_be", 32'(mem_be), 32'd0);
        req_valid = 0;
    endtask

    task automatic do_load(string tag, logic [1:0] off, logic [1:0] sz,
                           logic uns, logic [31:0] w);
        logic bad;
        bad = (sz == 2'b11) || (sz == 2'b10 && off != 0) || (sz == 2'b01 && off[0]);
        @(negedge clk);
        rsp_valid = 1; rsp_offset = off; rsp_size = sz; rsp_unsigned = uns; mem_rdata = w;
        @(negedge clk);
        check({tag, " load_valid"}, 32'(load_valid), 32'd1);
        check({tag, " load_misalign"}, 32'(load_misalign), 32'(bad));
        check({tag, " load_data"}, load_data, bad ? 32'd0 : want_load(sz, off, uns, w));
        rsp_valid = 0;
    endtask

    task automatic t_reset();
        idle_inputs();
        req_valid = 1; req_size = 2'b10; req_addr = 32'h40; req_wdata = 32'h1;
        rsp_valid = 1; mem_rdata = 32'hffff_ffff;
        rst = 1;
        repeat (3) @(negedge clk);
        check("R10 mem_valid", 32'(mem_valid), 0);
        check("R10 mem_be", 32'(mem_be), 0);
        check("R10 load_valid", 32'(load_valid), 0);
        check("R10 load_data", load_data, 0);
        idle_inputs();
        rst = 0;
        @(negedge clk);
        check("R10 mem_addr after", mem_addr, 0);
        check("R10 req_misalign after", 32'(req_misalign), 0);
    endtask

    task automatic t_store_word();
        do_req("R1 R2 word store", 1, 32'h0000_0100, 2'b10, 32'habcd_ef12);
        do_req("R2 word store", 1, 32'hffff_fffc, 2'b10, 32'h0123_4567);
    endtask

    task automatic t_store_half();
        do_req("R3 half off0", 1, 32'h0000_0200, 2'b01, 32'h1234_5678);
        do_req("R3 half off2", 1, 32'h0000_0202, 2'b01, 32'h1234_5678);
    endtask

    task automatic t_store_byte();
        for (int k = 0; k < 4; k++)
            do_req("R4 byte store", 1, 32'h0000_0300 + 32'(k), 2'b00, 32'h7766_55a5 + 32'(k));
    endtask

    task automatic t_store_misalign();
        do_bad_req(32'h0000_0301, 2'b01);
        do_bad_req(32'h0000_0303, 2'b01);
        do_bad_req(32'h0000_0302, 2'b10);
        do_bad_req(32'h0000_0301, 2'b10);
        do_bad_req(32'h0000_0300, 2'b11);
    endtask

    task automatic t_read_req();
        do_req("R12 read half", 0, 32'h0000_0402, 2'b01, 32'h5555_aaaa);
        do_req("R12 read byte", 0, 32'h0000_0401, 2'b00, 32'h5555_aaaa);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R11 mem_valid idle", 32'(mem_valid), 0);
        check("R11 mem_be idle", 32'(mem_be), 0);
        check("R11 mem_wdata idle", mem_wdata, 0);
        check("R11 load_valid idle", 32'(load_valid), 0);
        check("R11 load_data idle", load_data, 0);
    endtask

    task automatic t_load_word();
        do_load("R6 word load", 2'd0, 2'b10, 0, 32'habcd_ef12);
        do_load("R6 word load u", 2'd0, 2'b10, 1, 32'h8000_0001);
    endtask

    task automatic t_load_signed();
        for (int k = 0; k < 4; k++)
            do_load("R7 signed byte", 2'(k), 2'b00, 0, 32'habcd_ef12);
        do_load("R7 signed byte pos", 2'd0, 2'b00, 0, 32'h7f01_7ffe);
        do_load("R7 signed half off0", 2'd0, 2'b01, 0, 32'habcd_ef12);
        do_load("R7 signed half off2", 2'd2, 2'b01, 0, 32'habcd_ef12);
        do_load("R7 signed half pos", 2'd2, 2'b01, 0, 32'h8000_7ffe);
    endtask

    task automatic t_load_unsigned();
        for (int k = 0; k < 4; k++)
            do_load("R8 unsigned byte", 2'(k), 2'b00, 1, 32'habcd_ef12);
        do_load("R8 unsigned half off0", 2'd0, 2'b01, 1, 32'habcd_ef12);
        do_load("R8 unsigned half off2", 2'd2, 2'b01, 1, 32'habcd_ef12);
    endtask

    task automatic t_load_misalign();
        do_load("R9 half off1", 2'd1, 2'b01, 0, 32'hffff_ffff);
        do_load("R9 word off2", 2'd2, 2'b10, 1, 32'hffff_ffff);
        do_load("R9 bad size", 2'd0, 2'b11, 0, 32'hffff_ffff);
    endtask

    initial begin
        t_reset();
        t_store_word();
        t_idle();
        t_store_half();
        t_store_byte();
        t_store_misalign();
        t_idle();
        t_read_req();
        t_load_word();
        t_idle();
        t_load_signed();
        t_load_unsigned();
        t_load_misalign();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired before all scenarios ended");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule